// File: doc/BRIEF.md
# Dual-Line Edge-Selectable Interrupt Collector

This block gathers up to 32 (24 by default) external event inputs and reports them to two independent host agents. Each agent owns one active-low interrupt line together with a private status register and a private mask register, so the two hosts capture, inspect and silence events without disturbing each other. A single edge-select register, common to both agents, decides per input whether rising edges, falling edges, both or none are captured.

Hosts reach the block through a plain byte-wide register port. Read and write strobes are single-cycle, act at the next rising clock edge and are always accepted, so there is no back-pressure. Read data is combinational from the address. A control bit chooses between clear-on-read and write-one-to-clear status handling. An edge that arrives while its status bit is already set is held as a second pending event and reappears once the first one is cleared.

Top module: `dual_irq_collector`

## Requirements
- R1: After reset both interrupt lines are high, every status bit is 0, every mask bit is 1, every edge-select bit is 0 and the clear-on-read control bit is 0.
- R2: Input i is controlled by edge-select bits 2i+1 (rising edge) and 2i (falling edge), found in edge byte i>>2 at address 0x10 + (i>>2). Only the enabled direction sets a status bit.
- R3: An input whose two edge-select bits are both 0 never sets a status bit on either line, whatever its mask.
- R4: A selected edge sets the input's status bit on both lines, whether or not it is masked. Status becomes visible on the third rising clock edge after the input changes (two synchronizer stages, then edge compare).
- R5: Line L's output is low exactly while (status_L & ~mask_L) is nonzero. A mask bit of 1 disables that input for that line only; all ones silences the line.
- R6: With control bit 0 of address 0x18 at 0, writing ones to a status byte clears those bits, zero bits are left alone, and reads do not change status.
- R7: With control bit 0 at 1, reading a status byte clears all bits of that byte after returning them, and writes to status bytes have no effect.
- R8: An edge that arrives while its status bit is set is buffered; clearing the bit makes it reappear set, and a second clear leaves it 0.
- R9: If a selected edge and a clear of the same status bit fall in the same clock cycle, the bit stays set.
- R10: Register map: line 0 status at 0x00, line 0 mask at 0x04, line 1 status at 0x08, line 1 mask at 0x0C (each ceil(N/8) bytes, byte k holding inputs 8k..8k+7, least significant byte first), edge-select at 0x10 (ceil(2N/8) bytes), control at 0x18. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | Asynchronous event inputs |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_rd | input | 1 | Read strobe, one cycle per byte (drives clear-on-read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 2 | Active-low interrupt lines, bit L serves host L |

## Verification
The assertions on status stability take for granted that a host never raises read and write in the same cycle, since they only constrain the cycle after a lone read or a lone write. The stimulus keeps to this, and it holds each input pattern for four cycles before the next register access so that every edge has reached the status registers. The one exception is a deliberate case that lines up an edge with a write-one-to-clear in the same cycle to show that the edge wins. Random input flips, edge-select writes, mask writes, clears and mode changes are mixed with directed cases, and every read and interrupt level is compared against a bench model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [2:0] {
    GRP_NONE, GRP_STAT0, GRP_MASK0, GRP_STAT1, GRP_MASK1, GRP_EDGE, GRP_CTRL
  } reg_grp_e;

  typedef struct packed {
    reg_grp_e   grp;
    logic [2:0] idx;
  } reg_sel_t;

  // Map a byte address to a register group and a byte index inside it.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned nb,
                                           input int unsigned eb);
    reg_sel_t s;
    s.grp = GRP_NONE;
    s.idx = a[2:0];
    if (!a[4]) begin
      s.idx = {1'b0, a[1:0]};
      if (32'(a[1:0]) < nb) begin
        case (a[3:2])
          2'd0:    s.grp = GRP_STAT0;
          2'd1:    s.grp = GRP_MASK0;
          2'd2:    s.grp = GRP_STAT1;
          default: s.grp = GRP_MASK1;
        endcase
      end
    end else if (!a[3]) begin
      if (32'(a[2:0]) < eb) s.grp = GRP_EDGE;
    end else if (a[2:0] == 3'd0) begin
      s.grp = GRP_CTRL;
    end
    return s;
  endfunction
endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int unsigned N = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   evt_in,
  input  logic [2*N-1:0] cfg,
  output logic [N-1:0]   hit
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= evt_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // Odd bit of each pair arms rising capture, even bit arms falling capture.
  for (genvar i = 0; i < N; i++) begin : g_evt
    assign hit[i] = (cfg[2*i+1] &  sync_q[i] & ~prev_q[i])
                  | (cfg[2*i]   & ~sync_q[i] &  prev_q[i]);
  end
endmodule

// File: rtl/irqc_line_bank.sv
module irqc_line_bank #(
  parameter int unsigned N  = 24,
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hit,
  input  logic [N-1:0]  clr,
  input  logic [NB-1:0] mask_we,
  input  logic [7:0]    wdata,
  output logic [N-1:0]  stat,
  output logic [N-1:0]  mask,
  output logic          irq_n
);
  logic [N-1:0]    stat_q, pend_q;
  logic [NB*8-1:0] mask_q;

  // A clear hands the buffered event back to status; a fresh edge always wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | (pend_q & clr) | hit;
      pend_q <= (~clr & (pend_q | (stat_q & hit))) | (clr & pend_q & hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      for (int b = 0; b < int'(NB); b++) begin
        if (mask_we[b]) mask_q[b*8 +: 8] <= wdata;
      end
    end
  end

  assign stat  = stat_q;
  assign mask  = mask_q[N-1:0];
  assign irq_n = ~|(stat_q & ~mask_q[N-1:0]);

  AST_PEND_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~stat_q) == '0)); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> (($past(hit) & ~stat_q) == '0)); // R9
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit) & ~$past(pend_q)) == '0)); // R3
endmodule

// File: rtl/dual_irq_collector.sv
module dual_irq_collector
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_EVT = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [1:0]         irq_n
);
  localparam int unsigned STAT_BYTES = (NUM_EVT + 7) / 8;
  localparam int unsigned EDGE_BYTES = (2 * NUM_EVT + 7) / 8;

  if (NUM_EVT < 1 || NUM_EVT > 32) begin : g_bad_cfg
    $error("NUM_EVT must lie in 1..32");
  end

  reg_sel_t                sel;
  logic                    cor_q;
  logic [EDGE_BYTES*8-1:0] edge_q;
  logic [NUM_EVT-1:0]      hit;
  logic [NUM_EVT-1:0]      stat_l [2];
  logic [NUM_EVT-1:0]      mask_l [2];
  logic [STAT_BYTES*8-1:0] stat_pad [2];
  logic [STAT_BYTES*8-1:0] mask_pad [2];

  assign sel = decode_addr(reg_addr, STAT_BYTES, EDGE_BYTES);

  // Shared edge-select bytes and mode bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      cor_q  <= 1'b0;
    end else if (reg_wr) begin
      if (sel.grp == GRP_EDGE) edge_q[32'(sel.idx)*8 +: 8] <= reg_wdata;
      if (sel.grp == GRP_CTRL) cor_q <= reg_wdata[0];
    end
  end

  irqc_edge_detect #(.N(NUM_EVT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .cfg    (edge_q[2*NUM_EVT-1:0]),
    .hit    (hit)
  );

  for (genvar l = 0; l < 2; l++) begin : g_line
    localparam reg_grp_e STAT_GRP = (l == 0) ? GRP_STAT0 : GRP_STAT1;
    localparam reg_grp_e MASK_GRP = (l == 0) ? GRP_MASK0 : GRP_MASK1;

    logic [STAT_BYTES*8-1:0] clr_pad;
    logic [STAT_BYTES-1:0]   mask_we;

    always_comb begin
      clr_pad = '0;
      mask_we = '0;
      if (sel.grp == STAT_GRP) begin
        if (cor_q && reg_rd)       clr_pad[32'(sel.idx)*8 +: 8] = 8'hFF;
        else if (!cor_q && reg_wr) clr_pad[32'(sel.idx)*8 +: 8] = reg_wdata;
      end
      if (sel.grp == MASK_GRP && reg_wr) mask_we[sel.idx] = 1'b1;
    end

    irqc_line_bank #(.N(NUM_EVT), .NB(STAT_BYTES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .clr     (clr_pad[NUM_EVT-1:0]),
      .mask_we (mask_we),
      .wdata   (reg_wdata),
      .stat    (stat_l[l]),
      .mask    (mask_l[l]),
      .irq_n   (irq_n[l])
    );

    assign stat_pad[l] = (STAT_BYTES*8)'(stat_l[l]);
    assign mask_pad[l] = (STAT_BYTES*8)'(mask_l[l]);

    AST_W1C_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cor_q && reg_rd && !reg_wr) |=> (($past(stat_l[l]) & ~stat_l[l]) == '0)); // R6
    AST_COR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cor_q && reg_wr && !reg_rd) |=> (($past(stat_l[l]) & ~stat_l[l]) == '0)); // R7
  end

  always_comb begin
    case (sel.grp)
      GRP_STAT0: reg_rdata = stat_pad[0][32'(sel.idx)*8 +: 8];
      GRP_MASK0: reg_rdata = mask_pad[0][32'(sel.idx)*8 +: 8];
      GRP_STAT1: reg_rdata = stat_pad[1][32'(sel.idx)*8 +: 8];
      GRP_MASK1: reg_rdata = mask_pad[1][32'(sel.idx)*8 +: 8];
      GRP_EDGE:  reg_rdata = edge_q[32'(sel.idx)*8 +: 8];
      GRP_CTRL:  reg_rdata = {7'd0, cor_q};
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: tb/tb_dual_irq_collector.sv
`timescale 1ns/1ps
module tb_dual_irq_collector;
  localparam int N  = 24;
  localparam int NB = 3;
  localparam int EB = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_in = '0;
  logic [4:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic [1:0]   irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_irq_collector #(.NUM_EVT(N)) dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // Bench model of the requirements.
  logic [N-1:0]   m_stat [2];
  logic [N-1:0]   m_pend [2];
  logic [N-1:0]   m_mask [2];
  logic [2*N-1:0] m_edge;
  logic           m_cor;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void m_events(logic [N-1:0] oldv, logic [N-1:0] newv);
    logic [N-1:0] h = '0;
    for (int i = 0; i < N; i++)
      h[i] = (m_edge[2*i+1] & ~oldv[i] & newv[i]) | (m_edge[2*i] & oldv[i] & ~newv[i]);
    for (int l = 0; l < 2; l++) begin
      m_pend[l] = m_pend[l] | (m_stat[l] & h);
      m_stat[l] = m_stat[l] | h;
    end
  endfunction

  function automatic void m_clear(int l, int k, logic [7:0] bits);
    logic [N-1:0] c = N'(bits) << (8 * k);
    m_stat[l] = (m_stat[l] & ~c) | (m_pend[l] & c);
    m_pend[l] = m_pend[l] & ~c;
  endfunction

  function automatic void m_write(logic [4:0] a, logic [7:0] d);
    int l = int'(a[3]);
    int k = int'(a[1:0]);
    if (a < 5'h10) begin
      if (k < NB) begin
        if (a[2]) m_mask[l][8*k +: 8] = d;
        else if (!m_cor) m_clear(l, k, d);
      end
    end else if (a < 5'h18) begin
      if (int'(a[2:0]) < EB) m_edge[8*int'(a[2:0]) +: 8] = d;
    end else if (a == 5'h18) begin
      m_cor = d[0];
    end
  endfunction

  function automatic logic [7:0] m_read(logic [4:0] a);
    int l = int'(a[3]);
    int k = int'(a[1:0]);
    logic [7:0] r = 8'h00;
    if (a < 5'h10) begin
      if (k < NB) begin
        if (a[2]) r = m_mask[l][8*k +: 8];
        else begin
          r = m_stat[l][8*k +: 8];
          if (m_cor) m_clear(l, k, 8'hFF);
        end
      end
    end else if (a < 5'h18) begin
      if (int'(a[2:0]) < EB) r = m_edge[8*int'(a[2:0]) +: 8];
    end else if (a == 5'h18) begin
      r = {7'd0, m_cor};
    end
    return r;
  endfunction

  task automatic bus_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic bus_read(logic [4:0] a, string req);
    logic [7:0] e;
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    e = m_read(a);
    chk(req, 32'(reg_rdata), 32'(e), $sformatf("read addr %0h", a));
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic drive_evt(logic [N-1:0] v);
    logic [N-1:0] o = evt_in;
    @(negedge clk);
    evt_in = v;
    repeat (4) @(negedge clk);
    m_events(o, v);
  endtask

  task automatic check_irq(string req);
    logic [1:0] e;
    e[0] = ~|(m_stat[0] & ~m_mask[0]);
    e[1] = ~|(m_stat[1] & ~m_mask[1]);
    chk(req, 32'(irq_n), 32'(e), "irq_n");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] p;
    int op;
    int l;
    int k;
    void'($urandom(32'd4242));
    m_stat[0] = '0; m_stat[1] = '0; m_pend[0] = '0; m_pend[1] = '0;
    m_mask[0] = '1; m_mask[1] = '1; m_edge = '0; m_cor = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and both lines
    check_irq("R1");
    for (int a = 0; a < 25; a++) bus_read(5'(a), "R1");

    // R3: edges on an input with no edge selected are ignored
    bus_write(5'h04, 8'h00);
    drive_evt(24'h000001);
    drive_evt(24'h000000);
    bus_read(5'h00, "R3");
    bus_read(5'h08, "R3");
    check_irq("R3");

    // R4 and R5: rising edge of input 0 sets both lines, only line 0 unmasked
    bus_write(5'h10, 8'h02);
    drive_evt(24'h000001);
    bus_read(5'h00, "R4");
    bus_read(5'h08, "R4");
    check_irq("R5");
    chk("R5", 32'(irq_n), 32'h2, "irq_n line0 low line1 high");

    // R2: falling edge ignored when only rising is selected, then selectable
    drive_evt(24'h000000);
    bus_write(5'h00, 8'h01);
    bus_read(5'h00, "R2");
    check_irq("R2");
    bus_write(5'h10, 8'h01);
    drive_evt(24'h000001);
    bus_read(5'h00, "R2");
    drive_evt(24'h000000);
    bus_read(5'h00, "R2");

    // R6: write-one-to-clear mode
    bus_read(5'h00, "R6");
    bus_write(5'h00, 8'h00);
    bus_read(5'h00, "R6");
    bus_write(5'h00, 8'h01);
    bus_read(5'h00, "R6");
    check_irq("R6");

    // R8: second event buffered behind a set status bit
    bus_write(5'h10, 8'h03);
    drive_evt(24'h000001);
    drive_evt(24'h000000);
    bus_write(5'h00, 8'h01);
    bus_read(5'h00, "R8");
    chk("R8", 32'(m_stat[0][0]), 32'h1, "model reappear");
    bus_write(5'h00, 8'h01);
    bus_read(5'h00, "R8");
    check_irq("R8");

    // R9: edge and clear of input 1 in the same cycle
    bus_write(5'h10, 8'h0C);
    drive_evt(24'h000002);
    p = m_pend[0];
    @(negedge clk);
    evt_in = 24'h000000;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 5'h00; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    m_events(24'h000002, 24'h000000);
    m_stat[0][1] = 1'b1;
    m_pend[0][1] = p[1];
    bus_read(5'h00, "R9");
    bus_write(5'h00, 8'h02);
    bus_read(5'h00, "R9");

    // R7: clear-on-read mode, writes to status ignored
    bus_write(5'h18, 8'h01);
    bus_read(5'h18, "R7");
    drive_evt(24'h000002);
    bus_write(5'h00, 8'hFF);
    bus_read(5'h00, "R7");
    bus_read(5'h00, "R7");
    bus_read(5'h08, "R7");
    bus_read(5'h08, "R7");
    bus_read(5'h08, "R7");
    check_irq("R7");
    bus_write(5'h18, 8'h00);

    // R10: input 17 lives in edge byte 4 and status/mask byte 2 bit 1
    bus_write(5'h14, 8'h08);
    bus_write(5'h06, 8'hFD);
    drive_evt(24'h020002);
    bus_read(5'h02, "R10");
    bus_read(5'h06, "R10");
    bus_read(5'h14, "R10");
    bus_read(5'h1F, "R10");
    check_irq("R10");

    // R5: all-ones mask silences the line while status stays set
    bus_write(5'h06, 8'hFF);
    check_irq("R5");
    bus_read(5'h02, "R5");

    // Random phase
    for (int it = 0; it < 300; it++) begin
      op = $urandom_range(0, 9);
      l = $urandom_range(0, 1);
      k = $urandom_range(0, NB - 1);
      case (op)
        0, 1, 2: drive_evt(evt_in ^ (N'($urandom) & N'($urandom) & N'($urandom)));
        3:       bus_write(5'(16 + $urandom_range(0, EB - 1)), 8'($urandom));
        4:       bus_write(5'(4 + 8 * l + k), 8'($urandom));
        5, 6:    bus_read(5'($urandom_range(0, 31)), "R4");
        7:       bus_write(5'(8 * l + k), 8'($urandom));
        8:       bus_write(5'h18, 8'($urandom_range(0, 1)));
        default: bus_read(5'(8 * l + k), "R6");
      endcase
      check_irq("R5");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule